// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of one read or write burst in a synchronous DRAM interface with four banks. A column command pulses `start` with the first column and the current mode settings: a burst-length code and an ordering bit. The block captures all of them at that edge. From the next cycle on it presents one column address per beat, with `col_valid` high. It moves to the next beat on every clock where `advance` is high.

Bounded bursts wrap inside their aligned block of columns. The order is either a wrapping increment or an XOR of the beat index into the low bits. `col_last` marks the final beat. A full-page burst walks the whole 256-column row, wrapping from the top column to column 0, until `stop` ends it. A new `start` may arrive on any cycle, including the one right after the previous column command, and it replaces the burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after its release, `col_valid` and `col_last` are 0 and `col_addr` reads 0 until the first `start`.
- R2: A `start` seen at a clock edge makes `col_valid` 1 and `col_addr` equal to `start_col` after that edge (beat 0). At the same edge the block latches the length code (`mode_len`: 0→1, 1→2, 2→4, 3→8, 7→full page) and the ordering bit (`mode_ilv`: 0 sequential, 1 interleaved).
- R3: In sequential order with length BL, beat i keeps the column bits above log2(BL) and puts (start low bits + i) mod BL in the low log2(BL) bits.
- R4: In interleaved order with length BL, beat i keeps the upper bits and puts (start low bits) XOR i in the low log2(BL) bits.
- R5: In full-page mode beat i is (start_col + i) mod 256, so the burst wraps from column 255 to column 0. `mode_ilv` has no effect in this mode, and `col_last` is never 1.
- R6: `col_last` is 1 exactly on beat BL-1 of a bounded burst. When `advance` is seen on that beat, `col_valid` drops after the edge.
- R7: While a burst is active and `advance` is low, the address and beat do not change.
- R8: `stop` during an active burst drops `col_valid` after the edge. `stop` or `advance` while idle has no effect.
- R9: `start` has priority over `stop` and `advance`. A `start` during an active burst, including on its last beat or on the cycle after the previous `start`, begins the new burst at beat 0.
- R10: Changes on `mode_len` or `mode_ilv` after `start` do not affect the burst in progress.
- R11: The unused length codes 4, 5 and 6 behave as a burst of length 1, so `col_last` is 1 on beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_len | input | 3 | Burst-length code, sampled on `start` |
| mode_ilv | input | 1 | 1 selects interleaved order, sampled on `start` |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| advance | input | 1 | Move to the next beat |
| stop | input | 1 | End the active burst |
| col_valid | output | 1 | A beat address is presented |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a bounded burst |

## Verification
The bench builds the block with its default parameters: 8 column bits, a 3-bit length code, and a largest bounded burst of 8. With 8 column bits, a full-page run can cross the 255-to-0 wrap within a few beats of a start near the top of the row. All three unused length codes and both orderings at every bounded length are also reachable. Random traffic overlaps starts, stops and stalls, which exercises restarts on the last beat, mode changes during a burst, and idle-time stops.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W_DEF      = 8;
    localparam int LEN_W_DEF      = 3;
    localparam int MAX_LOG_BL_DEF = 3;
    localparam int FULL_CODE_DEF  = 7;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

endpackage

// File: rtl/burst_col_len_decode.sv
module burst_col_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W      = COL_W_DEF,
    parameter int LEN_W      = LEN_W_DEF,
    parameter int MAX_LOG_BL = MAX_LOG_BL_DEF,
    parameter int FULL_CODE  = FULL_CODE_DEF
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [COL_W-1:0] beat_mask,
    output logic             is_full
);

    localparam int NUM_LEN = MAX_LOG_BL + 1;

    logic [NUM_LEN-1:0]           hit;
    logic [NUM_LEN-1:0][COL_W-1:0] mask_of;

    // one decoder slice per bounded length; slice k gives BL = 2**k
    for (genvar k = 0; k < NUM_LEN; k++) begin : g_len
        assign hit[k]     = (len_code == LEN_W'(k));
        assign mask_of[k] = COL_W'((COL_W'(1) << k) - COL_W'(1));
    end

    always_comb begin
        is_full   = (len_code == LEN_W'(FULL_CODE));
        beat_mask = '0;
        if (is_full) begin
            beat_mask = '1;
        end else begin
            for (int k = 0; k < NUM_LEN; k++) begin
                if (hit[k]) beat_mask = mask_of[k];
            end
        end
    end

endmodule

// File: rtl/burst_col_addr.sv
module burst_col_addr
    import burst_col_pkg::*;
#(
    parameter int COL_W = COL_W_DEF
) (
    input  logic             active,
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] beat_mask,
    input  logic             is_full,
    input  order_e           order,
    output logic [COL_W-1:0] addr,
    output logic             last_beat
);

    logic [COL_W-1:0] lane;
    logic [COL_W-1:0] merged;

    always_comb begin
        if (order == ORD_ILV && !is_full) begin
            lane = base_col ^ beat_idx;
        end else begin
            lane = base_col + beat_idx;
        end
        merged    = (base_col & ~beat_mask) | (lane & beat_mask);
        addr      = active ? merged : '0;
        last_beat = active && !is_full && (beat_idx == beat_mask);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W      = COL_W_DEF,
    parameter int LEN_W      = LEN_W_DEF,
    parameter int MAX_LOG_BL = MAX_LOG_BL_DEF,
    parameter int FULL_CODE  = FULL_CODE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] mode_len,
    input  logic             mode_ilv,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             advance,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last
);

    typedef struct packed {
        logic             valid;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
        logic             full;
        order_e           order;
    } burst_state_t;

    burst_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] cur_addr;
    logic             cur_last;

    burst_col_len_decode #(
        .COL_W      (COL_W),
        .LEN_W      (LEN_W),
        .MAX_LOG_BL (MAX_LOG_BL),
        .FULL_CODE  (FULL_CODE)
    ) u_dec (
        .len_code  (mode_len),
        .beat_mask (dec_mask),
        .is_full   (dec_full)
    );

    burst_col_addr #(
        .COL_W (COL_W)
    ) u_addr (
        .active    (st_q.valid),
        .base_col  (st_q.base),
        .beat_idx  (st_q.cnt),
        .beat_mask (st_q.mask),
        .is_full   (st_q.full),
        .order     (st_q.order),
        .addr      (cur_addr),
        .last_beat (cur_last)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.valid = 1'b1;
            st_d.base  = start_col;
            st_d.cnt   = '0;
            st_d.mask  = dec_mask;
            st_d.full  = dec_full;
            st_d.order = mode_ilv ? ORD_ILV : ORD_SEQ;
        end else if (st_q.valid) begin
            if (stop) begin
                st_d.valid = 1'b0;
            end else if (advance) begin
                if (cur_last) begin
                    st_d.valid = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, base: '0, cnt: '0, mask: '0,
                      full: 1'b0, order: ORD_SEQ};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_valid = st_q.valid;
    assign col_addr  = cur_addr;
    assign col_last  = cur_last;

    AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && col_addr == $past(start_col)); // R2
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && advance && !col_last && !start && !stop && !st_q.full
        |=> ((col_addr ^ $past(col_addr)) & ~st_q.mask) == '0); // R3
    AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> !col_last); // R5
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && advance && !stop && !start |=> !col_valid); // R6
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !advance && !stop && !start
        |=> col_valid && $stable(col_addr)); // R7
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && stop && !start |=> !col_valid); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && !start |=> !col_valid); // R8

endmodule

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_len = '0;
    logic       mode_ilv = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       advance = 1'b0;
    logic       stop = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       col_last;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_valid = 0;
    int m_base = 0, m_i = 0, m_bl = 1;
    bit m_full = 0, m_ilv = 0;

    always #4 clk = ~clk;

    burst_col_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_len(mode_len), .mode_ilv(mode_ilv),
        .start(start), .start_col(start_col), .advance(advance), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
    );

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] ref_addr(input int base, input int i,
                                            input int bl, input bit full,
                                            input bit ilv);
        int blk, off;
        if (full) return 8'((base + i) % 256);
        blk = base - (base % bl);
        off = base % bl;
        if (ilv) return 8'(blk + (off ^ i));
        return 8'(blk + ((off + i) % bl));
    endfunction

    function automatic bit ref_last();
        return m_valid && !m_full && (m_i == m_bl - 1);
    endfunction

    task automatic check(input string tag);
        logic [7:0] ea;
        bit el;
        ea = m_valid ? ref_addr(m_base, m_i, m_bl, m_full, m_ilv) : 8'h00;
        el = ref_last();
        checks++;
        if (col_valid !== m_valid || col_addr !== ea || col_last !== el) begin
            errors++;
            $display("FAIL %s: valid/addr/last got %0b/%02h/%0b expected %0b/%02h/%0b",
                     tag, col_valid, col_addr, col_last, m_valid, ea, el);
        end
    endtask

    // check at the current negedge, drive, update model, wait one clock
    task automatic cyc(input bit s, input logic [7:0] sc, input logic [2:0] ml,
                       input bit mi, input bit adv, input bit stp, input string tag);
        check(tag);
        start = s; start_col = sc; mode_len = ml; mode_ilv = mi;
        advance = adv; stop = stp;
        if (s) begin
            m_valid = 1; m_base = sc; m_i = 0;
            m_bl = len_of(ml); m_full = (ml == 3'd7); m_ilv = mi;
        end else if (m_valid) begin
            if (stp) m_valid = 0;
            else if (adv) begin
                if (ref_last()) m_valid = 0;
                else m_i = m_full ? (m_i + 1) % 256 : m_i + 1;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, 8'h00, 3'd0, 0, 1, 1, "R1 after reset");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, "R8 idle stop/advance");

        // R3 sequential BL8 wrap from 0x0D
        cyc(1, 8'h0D, 3'd3, 0, 0, 0, "R2 start");
        for (int k = 0; k < 9; k++) cyc(0, 8'h00, 3'd0, 0, 1, 0, "R3 seq BL8 wrap");
        // R4 interleaved BL4 from 0x0E
        cyc(1, 8'h0E, 3'd2, 1, 0, 0, "R2 start ilv");
        for (int k = 0; k < 5; k++) cyc(0, 8'h00, 3'd0, 0, 1, 0, "R4 ilv BL4");
        // R4 interleaved BL8
        cyc(1, 8'hA5, 3'd3, 1, 1, 0, "R4 start");
        for (int k = 0; k < 8; k++) cyc(0, 8'h00, 3'd0, 0, 1, 0, "R4 ilv BL8");
        // R5 full page across 255->0, interleave bit ignored, then R8 stop
        cyc(1, 8'hFD, 3'd7, 1, 0, 0, "R5 start full");
        for (int k = 0; k < 6; k++) cyc(0, 8'h00, 3'd0, 0, 1, 0, "R5 full wrap");
        cyc(0, 8'h00, 3'd0, 0, 0, 1, "R8 stop full");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, "R8 after stop");
        // R7 hold
        cyc(1, 8'h31, 3'd2, 0, 0, 0, "R2 start BL4");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, "R7 step");
        for (int k = 0; k < 3; k++) cyc(0, 8'h00, 3'd0, 0, 0, 0, "R7 hold");
        // R10 mode change mid burst
        for (int k = 0; k < 3; k++) cyc(0, 8'h00, 3'd7, 1, 1, 0, "R10 mode change");
        // R9 back-to-back and start on last beat
        cyc(1, 8'h40, 3'd1, 0, 0, 0, "R9 first");
        cyc(1, 8'h77, 3'd1, 1, 1, 1, "R9 back-to-back");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, "R9 step");
        cyc(1, 8'h10, 3'd0, 0, 1, 0, "R9 start on last");
        cyc(0, 8'h00, 3'd0, 0, 1, 0, "R6 BL1 last");
        // R11 reserved codes
        for (int c = 4; c < 7; c++) begin
            cyc(1, 8'(c * 17), 3'(c), 0, 0, 0, "R11 start reserved");
            cyc(0, 8'h00, 3'd0, 0, 1, 0, "R11 reserved as BL1");
        end
        cyc(0, 8'h00, 3'd0, 0, 0, 0, "R6 idle after last");

        // constrained random traffic
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 3000; k++) begin
            bit s, adv, stp;
            s   = ($urandom % 6) == 0;
            adv = ($urandom % 4) != 0;
            stp = ($urandom % 20) == 0;
            cyc(s, 8'($urandom), 3'($urandom), 1'($urandom), adv, stp,
                "R2-R11 random");
        end
        check("R6 final");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule